// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block is the loop-control part of a fetch front end. It lets a program run up to three counted loops, nested inside one another, without any branch instruction in the loop bodies. Each loop level keeps a start address, an end address, a count of passes still to run and a reload value. One control register decides which end addresses are live and which counter each of them uses.

On every cycle the block compares the current fetch address with the live loop ends. It then returns the address to fetch next. On a hit whose counter is non-zero it sends fetch back to the loop start and decrements that counter. On a hit whose counter is zero it lets fetch fall through and restores the counter from its reload register, so the loop can run again on the next pass of an enclosing loop.

Software sets the block up through a small register port. The port also takes two write-only shortcut codes per level. One arms a loop whose body is several instructions long, and the other arms a loop whose body is a single instruction. Each does so in one write, using the address after the current instruction as the loop start.

Top module: `zol_loop_unit`

## Requirements
- R1: While reset is held and after it is released, the control register reads 0, redirect is 0 and next_pc equals fetch_pc + STEP (STEP = 4).
- R2: reg_addr[4:2] selects a kind and reg_addr[1:0] a level (0..2). Kinds 0 (start), 1 (end), 2 (count) and 3 (reload) read back the last value written at that level. Kind 4 at level 0 is the control register: it stores wdata[11:0] and reads bits 31:12 as 0.
- R3: For loop end k, control bits [4k+2:4k] are its counter designator and bit 4k+3 is its enable. Designator 001, 010 and 011 pick counter 0, 1 and 2. Designator 000, any 1xx code, or a clear enable bit disables that loop end.
- R4: When fetch_pc equals an enabled loop end k and the designated counter is non-zero, redirect is 1 and next_pc is start k. If fetch_en is 1, that counter decreases by one at the clock edge.
- R5: When fetch_pc equals an enabled loop end and the designated counter is zero, redirect is 0 and next_pc is fetch_pc + 4. If fetch_en is 1, that counter is loaded from its own reload register.
- R6: When several enabled loop ends match, the lowest-numbered loop end decides both the counter and the start address.
- R7: While fetch_en is 0, no counter changes, apart from a register write.
- R8: A write with kind 5 at level n sets start n to fetch_pc + 4, and sets both reload n and count n to wdata.
- R9: A write with kind 6 at level n does what kind 5 does and also sets end n to fetch_pc + 4.
- R10: When a register write and a loop-end counter update target the same counter in the same cycle, the written value is kept.
- R11: Kinds 5, 6 and 7, level 3, and kind 4 at levels 1 and 2 read as 0. Writes to kind 7, to level 3, or to kind 4 at levels 1 and 2 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | W | Address of the instruction being fetched |
| fetch_en | input | 1 | Fetch advances this cycle; enables counter updates |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: kind in [4:2], level in [1:0] |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data for reg_addr (combinational) |
| next_pc | output | W | Address to fetch next |
| redirect | output | 1 | Next fetch is a jump back to a loop start |

## Verification
A loop-end counter update and a register write can land on the same counter in the same cycle. The write may be a plain count write or a shortcut code for that level. The bench forces this collision once by direct stimulus, writing a new count while fetch sits on the loop end. It also lets the collision arise often in a random run that packs fetch addresses and loop ends into a 16-word window. Each case is judged by reading the counter back and comparing it with a bench model that applies the loop update first and the write after it. The same model also settles overlapping loop ends, which resolve by lowest index.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int NLOOP = 3;
  localparam int LVL_W = 2;
  localparam int CTRL_W = 4 * NLOOP;

  typedef enum logic [2:0] {
    K_START       = 3'd0,
    K_END         = 3'd1,
    K_COUNT       = 3'd2,
    K_RELOAD      = 3'd3,
    K_CTRL        = 3'd4,
    K_FAST_MULTI  = 3'd5,
    K_FAST_SINGLE = 3'd6,
    K_NONE        = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic       en;
    logic [2:0] dsg;
  } end_field_t;

  function automatic logic dsg_valid(input logic [2:0] d);
    return (d == 3'b001) || (d == 3'b010) || (d == 3'b011);
  endfunction
endpackage

// File: rtl/zol_end_match.sv
module zol_end_match
  import zol_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     end_addr,
  input  logic [3:0]       field,
  output logic             hit,
  output logic [LVL_W-1:0] csel
);
  end_field_t f;

  always_comb begin
    f    = end_field_t'(field);
    hit  = f.en && dsg_valid(f.dsg) && (pc == end_addr);
    csel = f.dsg[1:0] - 2'd1;
  end
endmodule

// File: rtl/zol_prio.sv
module zol_prio
  import zol_pkg::*;
(
  input  logic [NLOOP-1:0]            hits,
  input  logic [NLOOP-1:0][LVL_W-1:0] csels,
  output logic [NLOOP-1:0]            grant,
  output logic                        any,
  output logic [LVL_W-1:0]            win_lvl,
  output logic [LVL_W-1:0]            win_csel
);
  always_comb begin
    grant    = '0;
    win_lvl  = '0;
    win_csel = '0;
    for (int k = NLOOP - 1; k >= 0; k--) begin
      if (hits[k]) begin
        grant    = '0;
        grant[k] = 1'b1;
        win_lvl  = LVL_W'(k);
        win_csel = csels[k];
      end
    end
    any = |hits;
  end
endmodule

// File: rtl/zol_loop_regs.sv
module zol_loop_regs
  import zol_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_en,
  input  logic                    hit,
  input  logic [LVL_W-1:0]        csel,
  input  logic [W-1:0]            step_pc,
  input  logic                    we,
  input  logic [4:0]              addr,
  input  logic [W-1:0]            wdata,
  output logic [NLOOP-1:0][W-1:0] start_q,
  output logic [NLOOP-1:0][W-1:0] end_q,
  output logic [NLOOP-1:0][W-1:0] cnt_q,
  output logic [NLOOP-1:0][W-1:0] rld_q,
  output logic [CTRL_W-1:0]       ctrl_q
);
  logic [NLOOP-1:0][W-1:0] start_d, end_d, cnt_d, rld_d;
  logic [CTRL_W-1:0]       ctrl_d;
  logic                    upd_en;
  reg_kind_e               kind;
  logic [LVL_W-1:0]        lvl;

  assign kind   = reg_kind_e'(addr[4:2]);
  assign lvl    = addr[1:0];
  assign upd_en = we | (fetch_en & hit);

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    cnt_d   = cnt_q;
    rld_d   = rld_q;
    ctrl_d  = ctrl_q;
    // loop-end counter update first
    if (fetch_en && hit) begin
      if (cnt_q[csel] != '0) cnt_d[csel] = cnt_q[csel] - 1'b1;
      else                   cnt_d[csel] = rld_q[csel];
    end
    // register write overrides
    if (we && (lvl != 2'd3)) begin
      unique case (kind)
        K_START:  start_d[lvl] = wdata;
        K_END:    end_d[lvl]   = wdata;
        K_COUNT:  cnt_d[lvl]   = wdata;
        K_RELOAD: rld_d[lvl]   = wdata;
        K_CTRL:   if (lvl == 2'd0) ctrl_d = wdata[CTRL_W-1:0];
        K_FAST_MULTI: begin
          start_d[lvl] = step_pc;
          rld_d[lvl]   = wdata;
          cnt_d[lvl]   = wdata;
        end
        K_FAST_SINGLE: begin
          start_d[lvl] = step_pc;
          end_d[lvl]   = step_pc;
          rld_d[lvl]   = wdata;
          cnt_d[lvl]   = wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      rld_q   <= '0;
      ctrl_q  <= '0;
    end else if (upd_en) begin
      start_q <= start_d;
      end_q   <= end_d;
      cnt_q   <= cnt_d;
      rld_q   <= rld_d;
      ctrl_q  <= ctrl_d;
    end
  end
endmodule

// File: rtl/zol_loop_unit.sv
module zol_loop_unit
  import zol_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fetch_pc,
  input  logic         fetch_en,
  input  logic         reg_we,
  input  logic [4:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] next_pc,
  output logic         redirect
);
  logic [1:0]                  rst_sync;
  logic                        rst_core_n;
  logic [W-1:0]                step_pc;
  logic [NLOOP-1:0][W-1:0]     start_q, end_q, cnt_q, rld_q;
  logic [CTRL_W-1:0]           ctrl_q;
  logic [NLOOP-1:0]            hit_v, grant;
  logic [NLOOP-1:0][LVL_W-1:0] csel_v;
  logic                        hit_any, cnt_nz;
  logic [LVL_W-1:0]            win_lvl, win_csel;
  reg_kind_e                   rd_kind;
  logic [LVL_W-1:0]            rd_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign step_pc = fetch_pc + W'(STEP);

  for (genvar k = 0; k < NLOOP; k++) begin : g_end
    zol_end_match #(.W(W)) u_match (
      .pc       (fetch_pc),
      .end_addr (end_q[k]),
      .field    (ctrl_q[4*k +: 4]),
      .hit      (hit_v[k]),
      .csel     (csel_v[k])
    );
  end

  zol_prio u_prio (
    .hits     (hit_v),
    .csels    (csel_v),
    .grant    (grant),
    .any      (hit_any),
    .win_lvl  (win_lvl),
    .win_csel (win_csel)
  );

  zol_loop_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fetch_en (fetch_en),
    .hit      (hit_any),
    .csel     (win_csel),
    .step_pc  (step_pc),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .start_q  (start_q),
    .end_q    (end_q),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .ctrl_q   (ctrl_q)
  );

  assign cnt_nz   = hit_any && (cnt_q[win_csel] != '0);
  assign redirect = cnt_nz;
  assign next_pc  = cnt_nz ? start_q[win_lvl] : step_pc;

  assign rd_kind = reg_kind_e'(reg_addr[4:2]);
  assign rd_lvl  = reg_addr[1:0];

  always_comb begin
    reg_rdata = '0;
    if (rd_lvl != 2'd3) begin
      unique case (rd_kind)
        K_START:  reg_rdata = start_q[rd_lvl];
        K_END:    reg_rdata = end_q[rd_lvl];
        K_COUNT:  reg_rdata = cnt_q[rd_lvl];
        K_RELOAD: reg_rdata = rld_q[rd_lvl];
        K_CTRL:   if (rd_lvl == 2'd0) reg_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/zol_chk.sv
module zol_chk
  import zol_pkg::*;
#(
  parameter int W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fetch_en,
  input logic                        reg_we,
  input logic                        redirect,
  input logic [W-1:0]                next_pc,
  input logic                        hit_any,
  input logic [NLOOP-1:0]            grant,
  input logic [LVL_W-1:0]            win_csel,
  input logic [NLOOP-1:0][W-1:0]     start_q,
  input logic [NLOOP-1:0][W-1:0]     cnt_q,
  input logic [NLOOP-1:0][W-1:0]     rld_q,
  input logic [CTRL_W-1:0]           ctrl_q
);
  // R1
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      ctrl_in_reset_chk: assert (ctrl_q == '0);
    end
  end

  // R4
  redirect_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> hit_any);

  // R4
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (next_pc == start_q[0] || next_pc == start_q[1] || next_pc == start_q[2]));

  // R4
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && redirect && !reg_we) |=>
      (cnt_q[$past(win_csel)] == $past(cnt_q[win_csel]) - W'(1)));

  // R5
  count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && hit_any && !redirect && !reg_we) |=>
      (cnt_q[$past(win_csel)] == $past(rld_q[win_csel])));

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !reg_we) |=> $stable(cnt_q));
endmodule

bind zol_loop_unit zol_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .fetch_en (fetch_en),
  .reg_we   (reg_we),
  .redirect (redirect),
  .next_pc  (next_pc),
  .hit_any  (hit_any),
  .grant    (grant),
  .win_csel (win_csel),
  .start_q  (start_q),
  .cnt_q    (cnt_q),
  .rld_q    (rld_q),
  .ctrl_q   (ctrl_q)
);

// File: tb/tb_zol_loop_unit.sv
module tb_zol_loop_unit;
  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        fetch_en;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] next_pc;
  logic        redirect;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_start [3];
  logic [31:0] m_end   [3];
  logic [31:0] m_cnt   [3];
  logic [31:0] m_rld   [3];
  logic [11:0] m_ctrl;
  logic [31:0] last_next;
  int          n_redir;

  zol_loop_unit dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_en(fetch_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .next_pc(next_pc), .redirect(redirect)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [1:0] l = a[1:0];
    if (l == 2'd3) return 32'd0;
    case (a[4:2])
      3'd0: return m_start[l];
      3'd1: return m_end[l];
      3'd2: return m_cnt[l];
      3'd3: return m_rld[l];
      3'd4: return (l == 2'd0) ? {20'd0, m_ctrl} : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // expected next address from the requirement rules
  task automatic m_eval(input logic [31:0] pc, output logic [31:0] nxt,
                        output logic red, output logic hit, output int c);
    int win = -1;
    hit = 1'b0; c = 0;
    for (int k = 0; k < 3; k++) begin
      logic [2:0] d = m_ctrl[4*k +: 3];
      if (win < 0 && m_ctrl[4*k+3] && d >= 3'd1 && d <= 3'd3 && pc == m_end[k]) begin
        win = k; c = int'(d) - 1; hit = 1'b1;
      end
    end
    red = hit && (m_cnt[c] != 0);
    nxt = red ? m_start[win] : pc + 32'd4;
  endtask

  task automatic m_update(input logic [31:0] pc, input logic fen, input logic we,
                          input logic [4:0] a, input logic [31:0] wd);
    logic [31:0] nxt; logic red, hit; int c;
    logic [1:0] l = a[1:0];
    m_eval(pc, nxt, red, hit, c);
    if (fen && hit) begin
      if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
      else               m_cnt[c] = m_rld[c];
    end
    if (we && l != 2'd3) begin
      case (a[4:2])
        3'd0: m_start[l] = wd;
        3'd1: m_end[l]   = wd;
        3'd2: m_cnt[l]   = wd;
        3'd3: m_rld[l]   = wd;
        3'd4: if (l == 2'd0) m_ctrl = wd[11:0];
        3'd5: begin m_start[l] = pc + 4; m_rld[l] = wd; m_cnt[l] = wd; end
        3'd6: begin m_start[l] = pc + 4; m_end[l] = pc + 4; m_rld[l] = wd; m_cnt[l] = wd; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic fen, input logic we,
                      input logic [4:0] a, input logic [31:0] wd, input string tag);
    logic [31:0] nxt; logic red, hit; int c;
    @(negedge clk);
    fetch_pc = pc; fetch_en = fen; reg_we = we; reg_addr = a; reg_wdata = wd;
    #1;
    m_eval(pc, nxt, red, hit, c);
    chk({tag, " next_pc"}, next_pc, nxt);
    chk({tag, " redirect"}, {31'd0, redirect}, {31'd0, red});
    chk({tag, " rdata"}, reg_rdata, m_read(a));
    if (red && fen) n_redir++;
    last_next = nxt;
    m_update(pc, fen, we, a, wd);
    @(posedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] wd);
    step(32'h0000_0F00, 1'b0, 1'b1, a, wd, "R2 setup");
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    fetch_en = 1'b0; reg_we = 1'b0; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; fetch_pc = 32'd0; fetch_en = 1'b0; reg_we = 1'b0;
    reg_addr = 5'd0; reg_wdata = 32'd0; n_redir = 0;
    for (int k = 0; k < 3; k++) begin
      m_start[k] = 0; m_end[k] = 0; m_cnt[k] = 0; m_rld[k] = 0;
    end
    m_ctrl = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    reg_addr = 5'h10;
    #1;
    chk("R1 ctrl in reset", reg_rdata, 32'd0);
    chk("R1 next_pc in reset", next_pc, 32'd4);
    chk("R1 redirect in reset", {31'd0, redirect}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(32'd0, 1'b1, 1'b0, 5'h10, 32'd0, "R1 after reset");

    // R2: basic readback
    wr(5'h01, 32'h1234_5678);
    rd(5'h01, 32'h1234_5678, "R2 start1 readback");
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, 32'h0000_0FFF, "R2 ctrl upper bits zero");

    // R4/R5: nested loops, inner uses counter 0, outer counter 1
    wr(5'h00, 32'h10); wr(5'h04, 32'h14); wr(5'h08, 32'd2); wr(5'h0C, 32'd2);
    wr(5'h01, 32'h00); wr(5'h05, 32'h1C); wr(5'h09, 32'd1); wr(5'h0D, 32'd1);
    wr(5'h10, 32'h0A9);
    n_redir = 0;
    begin
      logic [31:0] pc = 32'd0;
      for (int i = 0; i < 24; i++) begin
        step(pc, 1'b1, 1'b0, 5'h1F, 32'd0, "R4/R5 nested");
        pc = last_next;
      end
      chk("R4 nested final pc", pc, 32'h20);
      chk("R4 nested redirect count", n_redir, 32'd5);
    end
    rd(5'h08, 32'd2, "R5 inner counter reloaded");
    rd(5'h09, 32'd1, "R5 outer counter reloaded");

    // R6: overlapping loop ends
    wr(5'h04, 32'h80); wr(5'h05, 32'h80); wr(5'h00, 32'h200); wr(5'h01, 32'h300);
    wr(5'h08, 32'd3); wr(5'h09, 32'd3);
    wr(5'h10, 32'h0A9);
    step(32'h80, 1'b1, 1'b0, 5'h1F, 32'd0, "R6 lowest wins");
    chk("R6 next_pc start0", last_next, 32'h200);
    rd(5'h08, 32'd2, "R6 counter0 decremented");
    rd(5'h09, 32'd3, "R6 counter1 untouched");

    // R3: reserved and none designators disable
    wr(5'h10, 32'h00C);
    step(32'h80, 1'b1, 1'b0, 5'h1F, 32'd0, "R3 reserved code");
    chk("R3 reserved falls through", last_next, 32'h84);
    wr(5'h10, 32'h008);
    step(32'h80, 1'b1, 1'b0, 5'h1F, 32'd0, "R3 none code");
    wr(5'h10, 32'h001);
    step(32'h80, 1'b1, 1'b0, 5'h1F, 32'd0, "R3 enable clear");
    chk("R3 enable clear falls through", last_next, 32'h84);

    // R7: no fetch_en
    wr(5'h10, 32'h009);
    step(32'h80, 1'b0, 1'b0, 5'h1F, 32'd0, "R7 hold");
    rd(5'h08, 32'd2, "R7 counter unchanged");

    // R8 / R9 fast init
    step(32'h40, 1'b0, 1'b1, 5'h16, 32'd7, "R8 fast multi");
    rd(5'h02, 32'h44, "R8 start2");
    rd(5'h0A, 32'd7, "R8 count2");
    rd(5'h0E, 32'd7, "R8 reload2");
    step(32'h60, 1'b0, 1'b1, 5'h19, 32'd5, "R9 fast single");
    rd(5'h05, 32'h64, "R9 end1");
    rd(5'h01, 32'h64, "R9 start1");
    rd(5'h16, 32'd0, "R11 write-only reads zero");

    // R10: collision of write and update on counter 0
    step(32'h80, 1'b1, 1'b1, 5'h08, 32'd9, "R10 collision");
    rd(5'h08, 32'd9, "R10 write wins");

    // R11: ignored writes
    step(32'h0, 1'b0, 1'b1, 5'h03, 32'hDEAD, "R11 level3 write");
    step(32'h0, 1'b0, 1'b1, 5'h1C, 32'hBEEF, "R11 kind7 write");
    step(32'h0, 1'b0, 1'b1, 5'h11, 32'h000, "R11 ctrl alias write");
    rd(5'h10, 32'h009, "R11 ctrl unchanged");
    for (int a = 0; a < 32; a++) rd(5'(a), m_read(5'(a)), "R11/R2 full readback");

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] pc = 32'h100 + 4 * ($urandom % 16);
      logic        we = ($urandom % 4) == 0;
      logic [4:0]  a  = 5'($urandom);
      logic [31:0] wd;
      case (a[4:2])
        3'd0, 3'd1: wd = 32'h100 + 4 * ($urandom % 16);
        3'd4:       wd = $urandom;
        default:    wd = $urandom % 4;
      endcase
      step(pc, 1'($urandom), we, a, wd, "R4/R5/R6/R10 random");
    end
    for (int a = 0; a < 32; a++) rd(5'(a), m_read(5'(a)), "R2 final readback");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule